// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block sits beside a real-time clock and switches the rest of the chip between running and a power-down sleep. Software puts the system to sleep by writing a command. The block then drops its power-enable output. While asleep it samples an active-low wakeup pin on each slow-clock tick. It accepts a wakeup only after the pin has been seen asserted on enough consecutive ticks.

Once a wakeup is accepted, the block restores power with a reset output already asserted. It holds that reset for a programmed number of ticks and then releases the system back to normal running. Both the debounce length and the reset length come from writable registers. Their low five bits do not exist, so each length is a whole number of 32-tick steps. A write larger than a field can hold saturates at the field's largest value.

Slow-clock ticks arrive as a one-cycle enable on the fast register clock. The wakeup pin is treated as already synchronous to that clock.

Top module: `hib_seq`

## Requirements
- R1: After reset, `powerEn` is 1, `sysReset` is 0, and register addresses 1, 2 and 3 read back 0.
- R2: While running, a write to address 0 with data bit 0 set drives `powerEn` low on the next cycle. A write to address 0 with bit 0 clear has no effect. Address 0 always reads 0.
- R3: A sleep command written while asleep, while filtering or while reset is asserted is ignored. This includes a command in the same cycle as the tick that ends the reset. `powerEn` stays 1 after such a reset ends.
- R4: Address 1 holds the wakeup filter length in bits 15:5. Other bits read 0 and are discarded on write. A written word above 0xFFE0 stores 0xFFE0.
- R5: Address 2 holds the reset length in bits 11:5. Other bits read 0 and are discarded on write. A written word above 0xFE0 stores 0xFE0.
- R6: With filter length F ≥ 1, a wakeup is accepted on the F-th consecutive tick on which `wakeN` is 0. On the next cycle `powerEn` and `sysReset` both become 1, and not before.
- R7: A tick seen with `wakeN` at 1 while asleep or filtering leaves power off and restarts the count. This also holds on the tick that would have completed the filter.
- R8: With filter length 0, a wakeup is accepted on the first tick on which `wakeN` is seen at 0.
- R9: With reset length R, `sysReset` falls on the cycle after the R-th tick since power returned. R = 0 gives a one-tick reset.
- R10: While running, `wakeN` and ticks have no effect on `powerEn` or `sysReset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sequencing clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle pulse per slow-clock tick |
| wakeN | input | 1 | Active-low wakeup pin, synchronous to clk |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 command, 1 filter, 2 reset length |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| powerEn | output | 1 | Power enable for the sleeping domain |
| sysReset | output | 1 | Reset for the domain, active high |

## Verification
Two events can meet in one cycle. The first is the wakeup pin releasing on exactly the tick that would complete the filter count. The bench provokes this by holding the pin low for one tick fewer than the filter length and then raising it on the next tick. It expects power to stay off and a full new count to be needed. The second is a sleep command written in the same cycle as the tick that ends the reset. The bench drives both strobes at once and expects the command to be dropped and power to stay on.

// File: rtl/hib_pkg.sv
package hib_pkg;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FILT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RST  = 2'd2;

  typedef enum logic [1:0] {
    PH_RUN    = 2'd0,
    PH_SLEEP  = 2'd1,
    PH_FILTER = 2'd2,
    PH_RESET  = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cnt_strobe_t;

  function automatic logic [63:0] fieldMask(input int hi, input int lo);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

endpackage

// File: rtl/hib_field_reg.sv
module hib_field_reg #(
  parameter int DATA_W = 32,
  parameter int HI = 15,
  parameter int LO = 5,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] SEL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] fieldVal
);
  import hib_pkg::*;

  localparam logic [DATA_W-1:0] MASK = DATA_W'(fieldMask(HI, LO));

  logic [HI:LO] field;
  logic         hit;

  assign hit = regWr && (regAddr == SEL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      field <= '0;
    end else if (hit) begin
      if (regWdata > MASK) field <= '1;
      else                 field <= regWdata[HI:LO];
    end
  end

  always_comb begin
    fieldVal = '0;
    fieldVal[HI:LO] = field;
  end

endmodule

// File: rtl/hib_datapath.sv
module hib_datapath #(
  parameter int DATA_W = 32,
  parameter int FILT_HI = 15,
  parameter int FILT_LO = 5,
  parameter int RST_HI = 11,
  parameter int RST_LO = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWr,
  input  logic [hib_pkg::ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]           regWdata,
  output logic [DATA_W-1:0]           regRdata,
  input  hib_pkg::cnt_strobe_t        strobe,
  output logic                        hibReq,
  output logic                        filtHit,
  output logic                        rstHit
);
  import hib_pkg::*;

  localparam int CNT_W = ((FILT_HI > RST_HI) ? FILT_HI : RST_HI) + 1;

  logic [DATA_W-1:0] filtVal;
  logic [DATA_W-1:0] rstVal;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    nextCnt;

  hib_field_reg #(
    .DATA_W(DATA_W), .HI(FILT_HI), .LO(FILT_LO),
    .ADDR_W(ADDR_W), .SEL(ADDR_FILT)
  ) u_filt (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .fieldVal(filtVal)
  );

  hib_field_reg #(
    .DATA_W(DATA_W), .HI(RST_HI), .LO(RST_LO),
    .ADDR_W(ADDR_W), .SEL(ADDR_RST)
  ) u_rst (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .fieldVal(rstVal)
  );

  assign hibReq = regWr && (regAddr == ADDR_CMD) && regWdata[0];

  always_comb begin
    unique case (regAddr)
      ADDR_FILT: regRdata = filtVal;
      ADDR_RST:  regRdata = rstVal;
      default:   regRdata = '0;
    endcase
  end

  // tick counter shared by filter and reset phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + 1'b1;
  end

  assign nextCnt = {1'b0, cnt} + 1'b1;
  assign filtHit = nextCnt >= {1'b0, filtVal[CNT_W-1:0]};
  assign rstHit  = nextCnt >= {1'b0, rstVal[CNT_W-1:0]};

endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic                  wakeN,
  input  logic                  hibReq,
  input  logic                  filtHit,
  input  logic                  rstHit,
  output hib_pkg::cnt_strobe_t  strobe,
  output logic                  powerEn,
  output logic                  sysReset
);
  import hib_pkg::*;

  phase_t phase, phaseNxt;

  always_comb begin
    phaseNxt = phase;
    strobe   = '0;
    unique case (phase)
      PH_RUN: begin
        if (hibReq) begin
          phaseNxt = PH_SLEEP;
          strobe.cntClr = 1'b1;
        end
      end
      PH_SLEEP: begin
        if (tickEn && !wakeN) begin
          if (filtHit) begin
            phaseNxt = PH_RESET;
            strobe.cntClr = 1'b1;
          end else begin
            phaseNxt = PH_FILTER;
            strobe.cntInc = 1'b1;
          end
        end
      end
      PH_FILTER: begin
        if (tickEn) begin
          if (wakeN) begin
            phaseNxt = PH_SLEEP;
            strobe.cntClr = 1'b1;
          end else if (filtHit) begin
            phaseNxt = PH_RESET;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      PH_RESET: begin
        if (tickEn) begin
          if (rstHit) begin
            phaseNxt = PH_RUN;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
      end
      default: phaseNxt = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_RUN;
    else       phase <= phaseNxt;
  end

  assign powerEn  = (phase == PH_RUN) || (phase == PH_RESET);
  assign sysReset = (phase == PH_RESET);

endmodule

// File: rtl/hib_seq.sv
module hib_seq #(
  parameter int DATA_W = 32,
  parameter int FILT_HI = 15,
  parameter int FILT_LO = 5,
  parameter int RST_HI = 11,
  parameter int RST_LO = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wakeN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              powerEn,
  output logic              sysReset
);
  import hib_pkg::*;

  cnt_strobe_t strobe;
  logic hibReq, filtHit, rstHit;

  hib_datapath #(
    .DATA_W(DATA_W), .FILT_HI(FILT_HI), .FILT_LO(FILT_LO),
    .RST_HI(RST_HI), .RST_LO(RST_LO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strobe(strobe),
    .hibReq(hibReq), .filtHit(filtHit), .rstHit(rstHit)
  );

  hib_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wakeN(wakeN),
    .hibReq(hibReq), .filtHit(filtHit), .rstHit(rstHit),
    .strobe(strobe), .powerEn(powerEn), .sysReset(sysReset)
  );

endmodule

// File: rtl/hib_seq_chk.sv
module hib_seq_chk #(
  parameter int DATA_W = 32,
  parameter int FILT_HI = 15,
  parameter int FILT_LO = 5,
  parameter int RST_HI = 11,
  parameter int RST_LO = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wakeN,
  input logic              regWr,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              powerEn,
  input logic              sysReset
);
  import hib_pkg::*;

  localparam logic [DATA_W-1:0] FMASK = DATA_W'(fieldMask(FILT_HI, FILT_LO));
  localparam logic [DATA_W-1:0] RMASK = DATA_W'(fieldMask(RST_HI, RST_LO));

  logic cmdWr;
  assign cmdWr = regWr && (regAddr == ADDR_CMD) && regWdata[0];

  // R2
  cmd_drops_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && powerEn && !sysReset) |=> !powerEn);

  // R3
  reset_keeps_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> powerEn);

  // R4
  filt_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_FILT) |-> ((regRdata & ~FMASK) == '0));

  // R5
  rst_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_RST) |-> ((regRdata & ~RMASK) == '0));

  // R6
  power_up_in_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerEn) |-> sysReset);

  // R7
  sleep_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!powerEn && !(tickEn && !wakeN)) |=> !powerEn);

  // R9
  reset_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysReset) |-> $past(tickEn));

  // R10
  run_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerEn && !sysReset && !cmdWr) |=> (powerEn && !sysReset));

endmodule

bind hib_seq hib_seq_chk #(
  .DATA_W(DATA_W), .FILT_HI(FILT_HI), .FILT_LO(FILT_LO),
  .RST_HI(RST_HI), .RST_LO(RST_LO)
) u_chk (.*);

// File: tb/hib_seq_test.sv
module hib_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wakeN = 1'b1;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        powerEn, sysReset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hib_seq uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wakeN(wakeN),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .powerEn(powerEn), .sysReset(sysReset)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkOut(input string req, input string what,
                        input logic pe, input logic sr);
    chk(req, {what, " powerEn"}, {31'b0, powerEn}, {31'b0, pe});
    chk(req, {what, " sysReset"}, {31'b0, sysReset}, {31'b0, sr});
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic tick(input logic w);
    @(negedge clk);
    wakeN = w; tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic ticks(input int n, input logic w);
    for (int i = 0; i < n; i++) tick(w);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    chkOut("R1", "after reset", 1'b1, 1'b0);
    regRead(2'd1, d); chk("R1", "filter reg", d, 32'h0);
    regRead(2'd2, d); chk("R1", "reset reg", d, 32'h0);
    regRead(2'd3, d); chk("R1", "unused addr", d, 32'h0);
  endtask

  task automatic test_regs();
    logic [31:0] d;
    regWrite(2'd1, 32'h0000_1234); regRead(2'd1, d);
    chk("R4", "filter masked", d, 32'h0000_1220);
    regWrite(2'd1, 32'h0001_001F); regRead(2'd1, d);
    chk("R4", "filter saturate", d, 32'h0000_FFE0);
    regWrite(2'd2, 32'h0000_0ABC); regRead(2'd2, d);
    chk("R5", "reset masked", d, 32'h0000_0AA0);
    regWrite(2'd2, 32'h0000_1000); regRead(2'd2, d);
    chk("R5", "reset saturate", d, 32'h0000_0FE0);
    regRead(2'd1, d);
    chk("R4", "filter kept", d, 32'h0000_FFE0);
    regRead(2'd0, d);
    chk("R2", "command reads zero", d, 32'h0);
  endtask

  task automatic test_cmd_zero();
    regWrite(2'd0, 32'h0000_0002);
    chkOut("R2", "bit0 clear command", 1'b1, 1'b0);
  endtask

  task automatic test_run_pin();
    ticks(3, 1'b0);
    chkOut("R10", "pin low while running", 1'b1, 1'b0);
    wakeN = 1'b1;
  endtask

  task automatic test_full_wake();
    regWrite(2'd1, 32'h20);
    regWrite(2'd2, 32'h20);
    regWrite(2'd0, 32'h1);
    chkOut("R2", "sleep command", 1'b0, 1'b0);
    ticks(3, 1'b1);
    chkOut("R7", "idle ticks asleep", 1'b0, 1'b0);
    ticks(31, 1'b0);
    chkOut("R6", "one tick short", 1'b0, 1'b0);
    tick(1'b0);
    chkOut("R6", "filter complete", 1'b1, 1'b1);
    ticks(31, 1'b1);
    chkOut("R9", "reset one tick short", 1'b1, 1'b1);
    tick(1'b1);
    chkOut("R9", "reset complete", 1'b1, 1'b0);
  endtask

  task automatic test_release();
    regWrite(2'd0, 32'h1);
    ticks(20, 1'b0);
    tick(1'b1);
    chkOut("R7", "early release", 1'b0, 1'b0);
    ticks(31, 1'b0);
    chkOut("R7", "count restarted", 1'b0, 1'b0);
    tick(1'b1);
    chkOut("R7", "release on final tick", 1'b0, 1'b0);
    ticks(31, 1'b0);
    chkOut("R7", "recount short", 1'b0, 1'b0);
    tick(1'b0);
    chkOut("R6", "accepted after recount", 1'b1, 1'b1);
    ticks(32, 1'b1);
    chkOut("R9", "back to run", 1'b1, 1'b0);
  endtask

  task automatic test_zero();
    regWrite(2'd1, 32'h1F);
    regWrite(2'd2, 32'h0);
    regWrite(2'd0, 32'h1);
    chkOut("R2", "sleep again", 1'b0, 1'b0);
    tick(1'b0);
    chkOut("R8", "zero filter first tick", 1'b1, 1'b1);
    tick(1'b1);
    chkOut("R9", "zero reset one tick", 1'b1, 1'b0);
  endtask

  task automatic test_ignore();
    regWrite(2'd2, 32'h20);
    regWrite(2'd0, 32'h1);
    regWrite(2'd0, 32'h1);
    chkOut("R3", "command while asleep", 1'b0, 1'b0);
    tick(1'b0);
    chkOut("R3", "wake after ignored cmd", 1'b1, 1'b1);
    regWrite(2'd0, 32'h1);
    chkOut("R3", "command during reset", 1'b1, 1'b1);
    ticks(31, 1'b1);
    @(negedge clk);
    tickEn = 1'b1; regWr = 1'b1; regAddr = 2'd0; regWdata = 32'h1;
    @(negedge clk);
    tickEn = 1'b0; regWr = 1'b0; regWdata = '0;
    chkOut("R3", "command on reset-ending tick", 1'b1, 1'b0);
    @(negedge clk);
    chkOut("R3", "power stays on", 1'b1, 1'b0);
    regWrite(2'd0, 32'h1);
    chkOut("R2", "command from run", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_regs();
    test_cmd_zero();
    test_run_pin();
    test_full_wake();
    test_release();
    test_zero();
    test_ignore();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule